// File: doc/BRIEF.md
# Real-Time Alarm and Cyclic Timer

This block keeps time from a slow system tick, supplied as a one-cycle enable on the core clock. A 40-bit counter advances on every tick. Four compare channels watch that counter. Two short channels match only its low 16 bits, so they fire again every 65,536 ticks. Two long channels match all 40 bits, so each fires once. Any channel that fires sets a sticky status bit and raises the RTC alarm output for one cycle. A separate cyclic counter has its own prescaler. It wraps at a programmable top value, and it raises its own alarm output on each wrap. The two outputs are meant to feed an interrupt controller as separate sources.

Software reaches the block through a byte-wide register port with an address, a write strobe and a read strobe. A five-byte counter value cannot be read in one access. Reading the top counter byte therefore captures the whole count in a snapshot, and the lower-byte reads that follow return that snapshot.

Top module: `tmr_unit`

## Requirements
- R1: The counter starts at zero after reset. It rises by exactly one on each cycle with `tick` high and holds otherwise, wrapping modulo 2^40. It is readable as bytes at addresses 0x08 (bits 7:0) through 0x0C (bits 39:32).
- R2: A read of address 0x0C returns live counter bits 39:32 and captures all 40 bits. Later reads of 0x08 to 0x0B return bytes of that capture, even if the counter has moved on.
- R3: Short channel n (n = 0, 1) has a threshold at addresses 0x10+2n (low byte) and 0x11+2n (high byte). It fires on the tick that makes the low 16 counter bits equal that threshold, and so fires again every 65,536 ticks. It then sets status bit n.
- R4: Long channel n (n = 0, 1) has a threshold at addresses 0x18+8n through 0x1C+8n, least significant byte first. It fires only on the tick that makes all 40 counter bits equal that threshold. It then sets status bit 2+n.
- R5: The select register at 0x00 enables channels: bits 0 and 1 for the short channels, bits 2 and 3 for the long channels, bit 4 for the cyclic alarm. A channel whose bit is clear sets no status bit and causes no pulse. `rtc_alarm` is high for exactly the one cycle after the clock edge on which any enabled channel fires.
- R6: Status (read at 0x01, bits 3:0) is sticky. Writing 0x02 clears each status bit whose data bit is 1. A channel that fires in the same cycle as a clear keeps its bit set.
- R7: The cyclic counter advances once per (P+1) ticks, where P is the prescaler at 0x03. The prescale count restarts once it reaches or exceeds P.
- R8: With top value T at 0x04 (low byte) and 0x05 (high byte), the cyclic counter goes to zero on the advance that finds it at or above T. When select bit 4 is set, that wrap makes `cyc_alarm` high for one cycle, which gives one pulse every (P+1)(T+1) ticks.
- R9: After reset, all registers and outputs read zero.
- R10: The select, prescaler, top and threshold registers read back what was written. Status reads in bits 3:0 with the upper bits zero. The clear address and unmapped addresses read 0x00. `rdata` updates on the clock edge where `rd_en` is high and holds at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable from the slow system clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rtc_alarm | output | 1 | One-cycle pulse when an enabled compare channel fires |
| cyc_alarm | output | 1 | One-cycle pulse when the cyclic counter wraps while enabled |

## Verification
Every result is due one clock edge after its stimulus. A tick presented in one cycle moves the counter, sets status and raises either alarm output at the very next rising edge. A read strobe loads `rdata` at that same edge, and a register write affects compares from the edge after it lands. The bench drives each stimulus on a falling edge and updates its own model as if the following rising edge had occurred. It then compares the outputs on the next falling edge, so every sample falls exactly one edge after its cause, with nothing in between. Status is compared through reads of address 0x01.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Datapath widths and channel counts
    localparam int CNT_W   = 40;
    localparam int SHORT_W = 16;
    localparam int PRE_W   = 8;
    localparam int CYC_W   = 16;
    localparam int N_SHORT = 2;
    localparam int N_LONG  = 2;
    localparam int ADDR_W  = 6;

    // Register byte addresses
    localparam int ADR_SEL     = 0;
    localparam int ADR_STAT    = 1;
    localparam int ADR_CLR     = 2;
    localparam int ADR_PRE     = 3;
    localparam int ADR_TOP     = 4;
    localparam int ADR_CNT     = 8;
    localparam int ADR_SHORT   = 16;
    localparam int ADR_LONG    = 24;
    localparam int LONG_STRIDE = 8;

    function automatic int nbytes(input int w);
        return (w + 7) / 8;
    endfunction

    // Cyclic timer configuration
    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [CYC_W-1:0] top;
    } cyc_cfg_t;

endpackage

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
    parameter int W = 16
) (
    input  logic         tick,
    input  logic         en,
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] thr,
    output logic         hit
);
    // A channel fires on the tick that brings the counter onto its threshold
    assign hit = tick & en & (nxt == thr);
endmodule

// File: rtl/tmr_cyclic.sv
module tmr_cyclic #(
    parameter int PRE_W = 8,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic [PRE_W-1:0] presc,
    input  logic [CYC_W-1:0] top,
    output logic             pulse
);
    logic [PRE_W-1:0] pcnt;
    logic [CYC_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt  <= '0;
            cyc   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (pcnt >= presc) begin
                    pcnt <= '0;
                    if (cyc >= top) begin
                        cyc   <= '0;
                        pulse <= en;
                    end else begin
                        cyc <= cyc + CYC_W'(1);
                    end
                end else begin
                    pcnt <= pcnt + PRE_W'(1);
                end
            end
        end
    end

    // R7: prescale count only moves on a tick
    p_pre_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(tick)) |-> $stable(pcnt));

    // R8: a wrap pulse leaves the cyclic count at zero
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (cyc == '0));

    // R8: a wrap pulse always follows a tick
    p_wrap_tick_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rtc_alarm,
    output logic              cyc_alarm
);
    localparam int N_ALM   = N_SHORT + N_LONG;
    localparam int SEL_W   = N_ALM + 1;
    localparam int CNT_B   = nbytes(CNT_W);
    localparam int SHORT_B = nbytes(SHORT_W);
    localparam int CYC_B   = nbytes(CYC_W);

    logic [CNT_W-1:0]                cnt, snap, cnt_nxt;
    logic [SEL_W-1:0]                sel;
    logic [N_ALM-1:0]                status, hits, clr_mask;
    logic [N_SHORT-1:0][SHORT_W-1:0] thr_s;
    logic [N_LONG-1:0][CNT_W-1:0]    thr_l;
    cyc_cfg_t                        cfg;
    logic                            wr_clr, snap_grab;
    logic [7:0]                      rd_val;

    assign cnt_nxt   = cnt + CNT_W'(1);
    assign wr_clr    = wr_en && (addr == ADDR_W'(ADR_CLR));
    assign clr_mask  = wr_clr ? wdata[N_ALM-1:0] : '0;
    assign snap_grab = rd_en && (addr == ADDR_W'(ADR_CNT + CNT_B - 1));

    // Compare channels
    for (genvar g = 0; g < N_SHORT; g++) begin : g_short
        tmr_cmp #(.W(SHORT_W)) u_cmp (
            .tick(tick), .en(sel[g]), .nxt(cnt_nxt[SHORT_W-1:0]),
            .thr(thr_s[g]), .hit(hits[g]));
    end
    for (genvar g = 0; g < N_LONG; g++) begin : g_long
        tmr_cmp #(.W(CNT_W)) u_cmp (
            .tick(tick), .en(sel[N_SHORT+g]), .nxt(cnt_nxt),
            .thr(thr_l[g]), .hit(hits[N_SHORT+g]));
    end

    tmr_cyclic #(.PRE_W(PRE_W), .CYC_W(CYC_W)) u_cyc (
        .clk(clk), .rst(rst), .tick(tick), .en(sel[N_ALM]),
        .presc(cfg.presc), .top(cfg.top), .pulse(cyc_alarm));

    // Counter, status and alarm
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            snap      <= '0;
            status    <= '0;
            rtc_alarm <= 1'b0;
        end else begin
            if (tick) cnt <= cnt_nxt;
            if (snap_grab) snap <= cnt;
            status    <= (status & ~clr_mask) | hits;
            rtc_alarm <= |hits;
        end
    end

    // Configuration writes
    always_ff @(posedge clk) begin
        if (rst) begin
            sel   <= '0;
            cfg   <= '0;
            thr_s <= '0;
            thr_l <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_SEL)) sel <= wdata[SEL_W-1:0];
            if (addr == ADDR_W'(ADR_PRE)) cfg.presc <= wdata[PRE_W-1:0];
            for (int b = 0; b < CYC_B; b++)
                if (addr == ADDR_W'(ADR_TOP + b)) cfg.top[b*8 +: 8] <= wdata;
            for (int i = 0; i < N_SHORT; i++)
                for (int b = 0; b < SHORT_B; b++)
                    if (addr == ADDR_W'(ADR_SHORT + i*SHORT_B + b))
                        thr_s[i][b*8 +: 8] <= wdata;
            for (int i = 0; i < N_LONG; i++)
                for (int b = 0; b < CNT_B; b++)
                    if (addr == ADDR_W'(ADR_LONG + i*LONG_STRIDE + b))
                        thr_l[i][b*8 +: 8] <= wdata;
        end
    end

    // Read mux
    always_comb begin
        rd_val = 8'h00;
        if (addr == ADDR_W'(ADR_SEL))  rd_val = 8'(sel);
        if (addr == ADDR_W'(ADR_STAT)) rd_val = 8'(status);
        if (addr == ADDR_W'(ADR_PRE))  rd_val = 8'(cfg.presc);
        for (int b = 0; b < CYC_B; b++)
            if (addr == ADDR_W'(ADR_TOP + b)) rd_val = cfg.top[b*8 +: 8];
        for (int b = 0; b < CNT_B; b++)
            if (addr == ADDR_W'(ADR_CNT + b))
                rd_val = (b == CNT_B - 1) ? cnt[b*8 +: 8] : snap[b*8 +: 8];
        for (int i = 0; i < N_SHORT; i++)
            for (int b = 0; b < SHORT_B; b++)
                if (addr == ADDR_W'(ADR_SHORT + i*SHORT_B + b))
                    rd_val = thr_s[i][b*8 +: 8];
        for (int i = 0; i < N_LONG; i++)
            for (int b = 0; b < CNT_B; b++)
                if (addr == ADDR_W'(ADR_LONG + i*LONG_STRIDE + b))
                    rd_val = thr_l[i][b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= 8'h00;
        else if (rd_en) rdata <= rd_val;
    end

    // R1: one step per tick
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tick)) |-> (cnt == $past(cnt) + CNT_W'(1)));

    // R1: no movement without a tick
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(tick)) |-> $stable(cnt));

    // R2: capture changes only on a top-byte read
    p_snap_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(snap_grab)) |-> $stable(snap));

    // R5: only selected channels may raise status bits
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((status & ~$past(status) & ~$past(sel[N_ALM-1:0])) == '0));

    // R5: the RTC alarm always follows a tick
    p_rtc_tick_r5: assert property (@(posedge clk) disable iff (rst)
        rtc_alarm |-> $past(tick));

    // R6: status bits only fall after a clear write
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wr_clr)) |-> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
    localparam logic [5:0] A_SEL = 6'h00, A_STAT = 6'h01, A_CLR = 6'h02,
                           A_PRE = 6'h03, A_TOPL = 6'h04, A_TOPH = 6'h05,
                           A_CNT0 = 6'h08, A_CNT4 = 6'h0C,
                           A_S0 = 6'h10, A_S1 = 6'h12, A_L0 = 6'h18, A_L1 = 6'h20;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rtc_alarm, cyc_alarm;

    always #5 clk = ~clk;

    tmr_unit dut (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata),
                  .rtc_alarm(rtc_alarm), .cyc_alarm(cyc_alarm));

    int n_run = 0, n_fail = 0;

    // Reference model state
    logic [39:0] m_cnt = '0, m_snap = '0;
    logic [4:0]  m_sel = '0;
    logic [3:0]  m_st = '0;
    logic [7:0]  m_pre = '0, m_pcnt = '0;
    logic [15:0] m_top = '0, m_cyc = '0;
    logic [15:0] m_s [2] = '{16'h0, 16'h0};
    logic [39:0] m_l [2] = '{40'h0, 40'h0};

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] f_read(input logic [5:0] a);
        if (a == A_SEL)  return {3'b0, m_sel};
        if (a == A_STAT) return {4'b0, m_st};
        if (a == A_PRE)  return m_pre;
        if (a == A_TOPL) return m_top[7:0];
        if (a == A_TOPH) return m_top[15:8];
        if (a >= A_CNT0 && a < A_CNT4) return m_snap[(a - A_CNT0)*8 +: 8];
        if (a == A_CNT4) return m_cnt[39:32];
        if (a >= A_S0 && a < A_S0 + 4) return m_s[(a - A_S0)/2][((a - A_S0)%2)*8 +: 8];
        if (a >= A_L0 && a < A_L0 + 5) return m_l[0][(a - A_L0)*8 +: 8];
        if (a >= A_L1 && a < A_L1 + 5) return m_l[1][(a - A_L1)*8 +: 8];
        return 8'h00;
    endfunction

    // One cycle: drive at falling edge, model the next rising edge, check at next falling edge
    task automatic step(input logic t, input logic w, input logic r,
                        input logic [5:0] a, input logic [7:0] d, input string req);
        logic [39:0] nx;
        logic [3:0]  h, clr;
        logic [7:0]  rv;
        logic        cp;
        tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
        nx = m_cnt + 40'd1;
        h = '0;
        for (int i = 0; i < 2; i++) begin
            if (t && m_sel[i] && nx[15:0] == m_s[i]) h[i] = 1'b1;
            if (t && m_sel[2+i] && nx == m_l[i]) h[2+i] = 1'b1;
        end
        rv = f_read(a);
        cp = 1'b0;
        if (t) begin
            if (m_pcnt >= m_pre) begin
                m_pcnt = '0;
                if (m_cyc >= m_top) begin m_cyc = '0; cp = m_sel[4]; end
                else m_cyc = m_cyc + 16'd1;
            end else m_pcnt = m_pcnt + 8'd1;
        end
        clr = (w && a == A_CLR) ? d[3:0] : 4'h0;
        m_st = (m_st & ~clr) | h;
        if (r && a == A_CNT4) m_snap = m_cnt;
        if (t) m_cnt = nx;
        if (w) begin
            if (a == A_SEL)  m_sel = d[4:0];
            if (a == A_PRE)  m_pre = d;
            if (a == A_TOPL) m_top[7:0] = d;
            if (a == A_TOPH) m_top[15:8] = d;
            if (a >= A_S0 && a < A_S0 + 4) m_s[(a - A_S0)/2][((a - A_S0)%2)*8 +: 8] = d;
            if (a >= A_L0 && a < A_L0 + 5) m_l[0][(a - A_L0)*8 +: 8] = d;
            if (a >= A_L1 && a < A_L1 + 5) m_l[1][(a - A_L1)*8 +: 8] = d;
        end
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        chk(req, "rtc_alarm", 64'(rtc_alarm), 64'(|h));
        chk(req, "cyc_alarm", 64'(cyc_alarm), 64'(cp));
        if (r) chk(req, $sformatf("rdata@%0h", a), 64'(rdata), 64'(rv));
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input string req);
        step(1'b0, 1'b1, 1'b0, a, d, req);
    endtask
    task automatic rd(input logic [5:0] a, input string req);
        step(1'b0, 1'b0, 1'b1, a, 8'h00, req);
    endtask
    task automatic ticks(input int n, input string req);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, 1'b0, 6'h00, 8'h00, req);
    endtask

    initial begin
        #(190000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int pulses;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9", "rtc_alarm", 64'(rtc_alarm), 64'd0);
        chk("R9", "cyc_alarm", 64'(cyc_alarm), 64'd0);
        chk("R9", "rdata", 64'(rdata), 64'd0);
        rd(A_SEL, "R9"); rd(A_STAT, "R9"); rd(A_CNT4, "R9"); rd(A_CNT0, "R9");

        // R10: register readback and unmapped reads
        wr(A_PRE, 8'h03, "R10"); wr(A_TOPL, 8'h34, "R10"); wr(A_TOPH, 8'h12, "R10");
        wr(A_L1 + 4, 8'hA5, "R10");
        rd(A_PRE, "R10"); rd(A_TOPL, "R10"); rd(A_TOPH, "R10"); rd(A_L1 + 4, "R10");
        rd(A_CLR, "R10"); rd(6'h3F, "R10"); rd(6'h07, "R10");

        // R3 and R5: short 0 enabled at 5, short 1 disabled at 9
        wr(A_S0, 8'd5, "R3"); wr(A_S0 + 1, 8'd0, "R3");
        wr(A_S1, 8'd9, "R5"); wr(A_S1 + 1, 8'd0, "R5");
        wr(A_L1 + 4, 8'h00, "R4");
        wr(A_SEL, 8'h01, "R5");
        ticks(12, "R3");
        rd(A_STAT, "R5");
        // R6: clear status
        wr(A_CLR, 8'h01, "R6");
        rd(A_STAT, "R6");

        // R4: long 0 at 20, long 1 shares low bits 0x18 but differs above
        wr(A_L0, 8'd20, "R4");
        wr(A_L1, 8'h18, "R4"); wr(A_L1 + 2, 8'h01, "R4");
        wr(A_SEL, 8'h0F, "R4");
        ticks(18, "R4");
        rd(A_STAT, "R4");

        // R6: fire and clear in the same cycle, set wins
        wr(A_S1, m_cnt[7:0] + 8'd1, "R6"); wr(A_S1 + 1, m_cnt[15:8], "R6");
        wr(A_CLR, 8'h0F, "R6");
        step(1'b1, 1'b1, 1'b0, A_CLR, 8'h0F, "R6");
        rd(A_STAT, "R6");

        // R1 and R2: snapshot coherent across further ticks
        rd(A_CNT4, "R2");
        ticks(7, "R1");
        for (int b = 0; b < 4; b++) rd(A_CNT0 + 6'(b), "R2");
        step(1'b1, 1'b0, 1'b1, A_CNT4, 8'h00, "R2");
        rd(A_CNT0, "R1");

        // R7 and R8: cyclic alarm every 12 ticks after settling
        wr(A_PRE, 8'd2, "R7"); wr(A_TOPL, 8'd3, "R8"); wr(A_TOPH, 8'd0, "R8");
        wr(A_SEL, 8'h10, "R8");
        ticks(24, "R8");
        pulses = 0;
        for (int k = 0; k < 48; k++) begin
            step(1'b1, 1'b0, 1'b0, 6'h00, 8'h00, "R7");
            if (cyc_alarm) pulses++;
        end
        chk("R7", "cyclic pulses in 48 ticks", 64'(pulses), 64'd4);
        // R8: top zero and no prescale, pulse on every tick
        wr(A_PRE, 8'd0, "R8"); wr(A_TOPL, 8'd0, "R8");
        ticks(6, "R8");
        // R5: cyclic disabled gives no pulse
        wr(A_SEL, 8'h00, "R5");
        ticks(6, "R5");

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            int op;
            logic t;
            op = int'($urandom % 12);
            t  = 1'($urandom % 2);
            case (op)
                0: step(t, 1'b1, 1'b0, A_SEL, 8'($urandom % 32), "R5");
                1: step(t, 1'b1, 1'b0, A_CLR, 8'($urandom % 16), "R6");
                2: step(t, 1'b1, 1'b0, A_S0 + 6'($urandom % 4),
                        ($urandom % 2) ? m_cnt[15:8] : m_cnt[7:0] + 8'($urandom % 6), "R3");
                3: step(t, 1'b1, 1'b0, A_L0 + 6'($urandom % 5),
                        m_cnt[((($urandom % 5)))*8 +: 8] + 8'($urandom % 3), "R4");
                4: step(t, 1'b1, 1'b0, A_PRE, 8'($urandom % 4), "R7");
                5: step(t, 1'b1, 1'b0, A_TOPL, 8'($urandom % 5), "R8");
                6: step(t, 1'b0, 1'b1, A_STAT, 8'h00, "R6");
                7: step(t, 1'b0, 1'b1, 6'($urandom % 64), 8'h00, "R10");
                8: step(t, 1'b0, 1'b1, A_CNT0 + 6'($urandom % 5), 8'h00, "R2");
                default: step(t, 1'b0, 1'b0, 6'h00, 8'h00, "R1");
            endcase
        end

        // R3: short channel repeats after 65536 ticks
        wr(A_SEL, 8'h01, "R3");
        wr(A_CLR, 8'h0F, "R3");
        wr(A_S0, m_cnt[7:0] + 8'd10, "R3");
        wr(A_S0 + 1, m_cnt[15:8] + ((m_cnt[7:0] >= 8'd246) ? 8'd1 : 8'd0), "R3");
        pulses = 0;
        for (int k = 0; k < 65560; k++) begin
            step(1'b1, 1'b0, 1'b0, 6'h00, 8'h00, "R3");
            if (rtc_alarm) pulses++;
        end
        chk("R3", "short wrap pulses", 64'(pulses), 64'd2);
        rd(A_STAT, "R3");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule